// File: doc/BRIEF.md
# Marching-Window Logic BIST Sequencer

This block runs a logic self-test session over a rectangular array of identical tiles. It does not test the whole array at once. It places a test window in the bottom-left corner of the array and runs a fixed pattern of steps at each window position. First the stimulus generator is seeded and the response compactor is cleared. Then the block runs full-speed bursts. Between bursts it shifts in a new configuration. After the last burst at a position, it folds the compactor into a running signature. The window then steps one column east. When a row of positions is done, the window moves up one row and the row pass starts again with a fresh load. After the last row, the signature is compared against an expected value.

Software sets the window size, the three loop counts, the seed and the expected signature through a small write-only register port, which stands in for a test data register. Each tile gets a 2-bit power state: fully on inside the window, partly on in the window's rows outside it (these tiles carry the east/west shared bus), and off everywhere else. The I/O interface stays disabled from the accepted start until the host confirms that it has read the signature.

Top module: `tileBistSeq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `pass`, `ioDisable`, `fastClkEn` and `shiftEn` are all 0, and every tile's power code is 2'b10 (full on), which is normal mode.
- R2: A `start` accepted while idle sets `busy` and `ioDisable` high by the next clock. `ioDisable` then stays high until `sigAck` is pulsed while `done` is high, and drops one cycle after that pulse.
- R3: Each row pass begins with SHIFT_LEN slow-shift cycles that load the window infrastructure with the window at column 0. These are followed by SHIFT_LEN slow-shift cycles that load the seed (address 5) into the stimulus generator, before the first burst of that row. The very first row of a session is row 0.
- R4: A burst holds `fastClkEn` high for exactly BURST_LEN consecutive cycles. `fastClkEn` and `shiftEn` are never high together.
- R5: Between two consecutive bursts at one window position there are exactly SHIFT_LEN reconfiguration shift cycles. Each position gets the number of bursts written at address 2, and a value of 0 behaves as 1.
- R6: Positions follow raster order. Within a row the window column goes 0, 1, 2 … up to the count at address 3. Then the row goes up by one and the column returns to 0, for the number of rows at address 4. A value of 0 at either address behaves as 1.
- R7: Address 0 sets the window width (1..COLS columns) and address 1 sets its height (1..8 rows). While busy, tile (column c, row r) has its code at `tilePower` bits [2(r*COLS+c)+1 : 2(r*COLS+c)]. The code is 2'b10 inside the window, 2'b01 in the window's rows outside its columns, and 2'b00 in all other rows.
- R8: The signature is cleared when a session starts. At the end of each position the compactor is folded in as sig = step(sig XOR compactor), where step is a left shift with feedback polynomial 0x04C11DB7. The same configuration always gives the same signature, and a different seed gives a different one.
- R9: `done` rises after the last position has been folded. `pass` is then 1 exactly when the signature equals the expected value at address 6.
- R10: A `start` pulse while `busy` is high is ignored. This covers both the running session and the hold phase after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| start | input | 1 | Session start request |
| sigAck | input | 1 | Host has read the final signature |
| tileResp | input | 32 | Tile outputs captured by the compactor |
| ioDisable | output | 1 | I/O interface disabled |
| shiftEn | output | 1 | Slow shift clock enable |
| fastClkEn | output | 1 | Full-speed burst clock enable |
| stimOut | output | 32 | Pseudo-random stimulus to the tiles |
| winCol | output | 3 | Window west column |
| winRow | output | 3 | Window bottom row |
| tilePower | output | 128 | Per-tile 2-bit power state |
| busy | output | 1 | Session in progress or awaiting readout |
| done | output | 1 | Session finished; pass is valid |
| pass | output | 1 | Signature matched the expected value |
| signature | output | 32 | Running and final signature |

## Verification
The hardest cases to reach from the ports are the loop boundaries. These include the shift gap at a row change, which is three shift phases long, compared with one between bursts. Another is the column reset when the window climbs a row. A third is a start request that arrives in the middle of a session or during the readout hold. The stimulus drives several sessions with different window shapes and loop counts, including a 1x1 window with a zero burst count and a full-height window. A scoreboard predicts every burst's position, shift gap and power map in raster order and checks them as the bursts appear. Repeat and changed-seed sessions then expose the signature and pass behaviour.

// File: rtl/bistSeqPkg.sv
package bistSeqPkg;

  localparam int SIG_W = 32;
  localparam logic [SIG_W-1:0] SIG_POLY = 32'h04C1_1DB7;

  localparam logic [2:0] CFG_WIN_W   = 3'd0;
  localparam logic [2:0] CFG_WIN_H   = 3'd1;
  localparam logic [2:0] CFG_N_BURST = 3'd2;
  localparam logic [2:0] CFG_N_COL   = 3'd3;
  localparam logic [2:0] CFG_N_ROW   = 3'd4;
  localparam logic [2:0] CFG_SEED    = 3'd5;
  localparam logic [2:0] CFG_EXPECT  = 3'd6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_IODIS, ST_ROWLOAD, ST_SEED, ST_BURST,
    ST_RECONF, ST_FOLD, ST_MOVE, ST_CHECK, ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic clearSig;
    logic loadSeed;
    logic burst;
    logic reshift;
    logic fold;
    logic compare;
  } seqStrobe_t;

  function automatic logic [SIG_W-1:0] sigStep(input logic [SIG_W-1:0] v);
    return {v[SIG_W-2:0], 1'b0} ^ (v[SIG_W-1] ? SIG_POLY : '0);
  endfunction

endpackage

// File: rtl/bistSeqCtrl.sv
module bistSeqCtrl
  import bistSeqPkg::*;
#(
  parameter int COLS      = 8,
  parameter int ROWS      = 8,
  parameter int CNT_W     = 8,
  parameter int BURST_LEN = 6,
  parameter int SHIFT_LEN = 4,
  localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             start,
  input  logic             sigAck,
  output seqStrobe_t       strobe,
  output logic             shiftEn,
  output logic             fastClkEn,
  output logic             busy,
  output logic             done,
  output logic [COL_W-1:0] winCol,
  output logic [ROW_W-1:0] winRow,
  output logic [CNT_W-1:0] winW,
  output logic [CNT_W-1:0] winH
);

  localparam int PH_MAX = (BURST_LEN > SHIFT_LEN) ? BURST_LEN : SHIFT_LEN;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  seqState_t state;
  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] reconfCnt, colCnt, rowCnt;
  logic [CNT_W-1:0] nBurstReg, nColReg, nRowReg;
  logic shiftLast, burstLast, reconfLast, colLast, rowLast;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winW      <= CNT_W'(1);
      winH      <= CNT_W'(1);
      nBurstReg <= CNT_W'(1);
      nColReg   <= CNT_W'(1);
      nRowReg   <= CNT_W'(1);
    end else if (cfgWe) begin
      case (cfgAddr)
        CFG_WIN_W:   winW      <= cfgCount;
        CFG_WIN_H:   winH      <= cfgCount;
        CFG_N_BURST: nBurstReg <= cfgCount;
        CFG_N_COL:   nColReg   <= cfgCount;
        CFG_N_ROW:   nRowReg   <= cfgCount;
        default: ;
      endcase
    end
  end

  assign shiftLast  = (phaseCnt == PH_W'(SHIFT_LEN - 1));
  assign burstLast  = (phaseCnt == PH_W'(BURST_LEN - 1));
  // a zero count behaves like one
  assign reconfLast = ({1'b0, reconfCnt} + 1'b1) >= {1'b0, nBurstReg};
  assign colLast    = ({1'b0, colCnt} + 1'b1) >= {1'b0, nColReg};
  assign rowLast    = ({1'b0, rowCnt} + 1'b1) >= {1'b0, nRowReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      reconfCnt <= '0;
      colCnt    <= '0;
      rowCnt    <= '0;
      winCol    <= '0;
      winRow    <= '0;
      done      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_IODIS;
          done   <= 1'b0;
          winCol <= '0;
          winRow <= '0;
        end
        ST_IODIS: begin
          state    <= ST_ROWLOAD;
          phaseCnt <= '0;
          colCnt   <= '0;
          rowCnt   <= '0;
        end
        ST_ROWLOAD: begin
          if (shiftLast) begin
            phaseCnt <= '0;
            state    <= ST_SEED;
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        ST_SEED: begin
          if (shiftLast) begin
            phaseCnt  <= '0;
            reconfCnt <= '0;
            state     <= ST_BURST;
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        ST_BURST: begin
          if (burstLast) begin
            phaseCnt <= '0;
            state    <= ST_RECONF;
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        ST_RECONF: begin
          if (shiftLast) begin
            phaseCnt <= '0;
            if (reconfLast) state <= ST_FOLD;
            else begin
              reconfCnt <= reconfCnt + 1'b1;
              state     <= ST_BURST;
            end
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        ST_FOLD: state <= ST_MOVE;
        ST_MOVE: begin
          reconfCnt <= '0;
          if (colLast) begin
            colCnt <= '0;
            winCol <= '0;
            if (rowLast) state <= ST_CHECK;
            else begin
              rowCnt <= rowCnt + 1'b1;
              winRow <= winRow + 1'b1;
              state  <= ST_ROWLOAD;
            end
          end else begin
            colCnt <= colCnt + 1'b1;
            winCol <= winCol + 1'b1;
            state  <= ST_BURST;
          end
        end
        ST_CHECK: begin
          done  <= 1'b1;
          state <= ST_HOLD;
        end
        ST_HOLD: if (sigAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clearSig = (state == ST_IODIS);
    strobe.loadSeed = (state == ST_SEED);
    strobe.burst    = (state == ST_BURST);
    strobe.reshift  = (state == ST_RECONF);
    strobe.fold     = (state == ST_FOLD);
    strobe.compare  = (state == ST_CHECK);
  end

  assign shiftEn   = (state == ST_ROWLOAD) || (state == ST_SEED) || (state == ST_RECONF);
  assign fastClkEn = (state == ST_BURST);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/bistSeqData.sv
module bistSeqData
  import bistSeqPkg::*;
#(
  parameter int COLS  = 8,
  parameter int ROWS  = 8,
  parameter int CNT_W = 8,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgAddr,
  input  logic [SIG_W-1:0]       cfgData,
  input  seqStrobe_t             strobe,
  input  logic                   busy,
  input  logic [SIG_W-1:0]       tileResp,
  input  logic [COL_W-1:0]       winCol,
  input  logic [ROW_W-1:0]       winRow,
  input  logic [CNT_W-1:0]       winW,
  input  logic [CNT_W-1:0]       winH,
  output logic [SIG_W-1:0]       stimOut,
  output logic [SIG_W-1:0]       signature,
  output logic                   pass,
  output logic [2*COLS*ROWS-1:0] tilePower
);

  logic [SIG_W-1:0] seedReg, expReg, lfsr, misr, sigReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedReg <= '0;
      expReg  <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == CFG_SEED)   seedReg <= cfgData;
      if (cfgAddr == CFG_EXPECT) expReg  <= cfgData;
    end
  end

  // stimulus generator and response compactor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= '0;
      misr <= '0;
    end else begin
      if (strobe.loadSeed) lfsr <= seedReg;
      else if (strobe.burst || strobe.reshift) lfsr <= sigStep(lfsr);

      if (strobe.loadSeed || strobe.fold) misr <= '0;
      else if (strobe.burst) misr <= sigStep(misr) ^ tileResp;
    end
  end

  // running signature and verdict
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigReg <= '0;
      pass   <= 1'b0;
    end else begin
      if (strobe.clearSig) begin
        sigReg <= '0;
        pass   <= 1'b0;
      end else begin
        if (strobe.fold)    sigReg <= sigStep(sigReg ^ misr);
        if (strobe.compare) pass   <= (sigReg == expReg);
      end
    end
  end

  assign stimOut   = lfsr;
  assign signature = sigReg;

  // per-tile power state map
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    logic rowIn;
    assign rowIn = (r >= int'(winRow)) && (r < int'(winRow) + int'(winH));
    for (genvar c = 0; c < COLS; c++) begin : gCol
      logic colIn;
      assign colIn = (c >= int'(winCol)) && (c < int'(winCol) + int'(winW));
      assign tilePower[2*(r*COLS+c) +: 2] =
        !busy ? 2'b10 : (rowIn ? (colIn ? 2'b10 : 2'b01) : 2'b00);
    end
  end

endmodule

// File: rtl/tileBistSeq.sv
module tileBistSeq
  import bistSeqPkg::*;
#(
  parameter int COLS      = 8,
  parameter int ROWS      = 8,
  parameter int CNT_W     = 8,
  parameter int BURST_LEN = 6,
  parameter int SHIFT_LEN = 4,
  localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgAddr,
  input  logic [31:0]            cfgData,
  input  logic                   start,
  input  logic                   sigAck,
  input  logic [31:0]            tileResp,
  output logic                   ioDisable,
  output logic                   shiftEn,
  output logic                   fastClkEn,
  output logic [31:0]            stimOut,
  output logic [COL_W-1:0]       winCol,
  output logic [ROW_W-1:0]       winRow,
  output logic [2*COLS*ROWS-1:0] tilePower,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic [31:0]            signature
);

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] winW, winH;

  bistSeqCtrl #(
    .COLS(COLS), .ROWS(ROWS), .CNT_W(CNT_W),
    .BURST_LEN(BURST_LEN), .SHIFT_LEN(SHIFT_LEN)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgCount(cfgData[CNT_W-1:0]), .start(start), .sigAck(sigAck),
    .strobe(strobe), .shiftEn(shiftEn), .fastClkEn(fastClkEn),
    .busy(busy), .done(done), .winCol(winCol), .winRow(winRow),
    .winW(winW), .winH(winH)
  );

  bistSeqData #(.COLS(COLS), .ROWS(ROWS), .CNT_W(CNT_W)) dataI (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .strobe(strobe), .busy(busy), .tileResp(tileResp),
    .winCol(winCol), .winRow(winRow), .winW(winW), .winH(winH),
    .stimOut(stimOut), .signature(signature), .pass(pass),
    .tilePower(tilePower)
  );

  assign ioDisable = busy;

endmodule

// File: rtl/bistSeqChk.sv
module bistSeqChk #(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   ioDisable,
  input logic                   fastClkEn,
  input logic                   shiftEn,
  input logic [COL_W-1:0]       winCol,
  input logic [ROW_W-1:0]       winRow,
  input logic [2*COLS*ROWS-1:0] tilePower
);

  // R2
  done_holds_io_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastClkEn || done |-> ioDisable || !busy && !fastClkEn);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fastClkEn && shiftEn));

  // R7
  win_origin_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastClkEn |-> tilePower[(int'(winRow)*COLS + int'(winCol))*2 +: 2] == 2'b10);

  // R6
  row_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> winRow >= $past(winRow));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done && start |=> busy && !done);

  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> busy && !fastClkEn && !shiftEn);

endmodule

bind tileBistSeq bistSeqChk #(.COLS(COLS), .ROWS(ROWS)) chkI (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .ioDisable(ioDisable), .fastClkEn(fastClkEn), .shiftEn(shiftEn),
  .winCol(winCol), .winRow(winRow), .tilePower(tilePower)
);

// File: tb/tileBistSeq_test.sv
module tileBistSeq_test;

  localparam int COLS = 8;
  localparam int ROWS = 8;
  localparam int BL   = 6;
  localparam int SL   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic start = 1'b0;
  logic sigAck = 1'b0;
  logic [31:0] tileResp;
  logic ioDisable, shiftEn, fastClkEn, busy, done, pass;
  logic [31:0] stimOut, signature;
  logic [2:0] winCol, winRow;
  logic [2*COLS*ROWS-1:0] tilePower;

  always #2.5 clk = ~clk;

  assign tileResp = stimOut ^ {stimOut[15:0], stimOut[31:16]} ^ 32'h1357_9BDF;

  tileBistSeq #(.COLS(COLS), .ROWS(ROWS), .CNT_W(8), .BURST_LEN(BL), .SHIFT_LEN(SL)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .start(start), .sigAck(sigAck), .tileResp(tileResp), .ioDisable(ioDisable),
    .shiftEn(shiftEn), .fastClkEn(fastClkEn), .stimOut(stimOut), .winCol(winCol),
    .winRow(winRow), .tilePower(tilePower), .busy(busy), .done(done), .pass(pass),
    .signature(signature)
  );

  typedef struct {int col; int row; int gap;} burstItem_t;
  burstItem_t expQ[$];

  int checks = 0;
  int errs = 0;
  int cfgW = 1;
  int cfgH = 1;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expPow(int c, int r, int wc, int wr);
    if (r >= wr && r < wr + cfgH) return (c >= wc && c < wc + cfgW) ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  // monitor: pops one expected item per burst
  bit prevFast = 1'b0;
  int burstLen = 0;
  int shiftCnt = 0;
  always @(negedge clk) begin
    if (!rstN || !busy) shiftCnt = 0;
    if (rstN && busy && !ioDisable) chk(1'b0, "R2", "ioDisable low while busy", 0, 1);
    if (fastClkEn && !prevFast) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10", "unexpected burst", 1, 0);
      end else begin
        burstItem_t it;
        int badIdx;
        it = expQ.pop_front();
        chk(int'(winCol) == it.col, "R6", "burst column", winCol, it.col);
        chk(int'(winRow) == it.row, "R6", "burst row", winRow, it.row);
        chk(shiftCnt == it.gap, (it.gap == SL) ? "R5" : "R3", "shift cycles before burst",
            shiftCnt, it.gap);
        badIdx = -1;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++)
            if (badIdx < 0 && tilePower[2*(r*COLS+c) +: 2] != expPow(c, r, it.col, it.row))
              badIdx = r*COLS + c;
        chk(badIdx < 0, "R7", "tile power map (first bad tile index in actual)",
            badIdx, -1);
      end
      shiftCnt = 0;
      burstLen = 1;
    end else if (fastClkEn) begin
      burstLen++;
    end else if (prevFast) begin
      chk(burstLen == BL, "R4", "burst length", burstLen, BL);
    end
    if (shiftEn) shiftCnt++;
    prevFast = fastClkEn;
  end

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // driver: programs a session and queues its expected bursts
  task automatic runSession(input int w, input int h, input int nb, input int nc,
                            input int nr, input logic [31:0] seed,
                            input logic [31:0] expSig, output logic [31:0] sigOut);
    int nbE, ncE, nrE;
    cfgW = w; cfgH = h;
    cfgWrite(3'd0, w); cfgWrite(3'd1, h); cfgWrite(3'd2, nb);
    cfgWrite(3'd3, nc); cfgWrite(3'd4, nr); cfgWrite(3'd5, seed);
    cfgWrite(3'd6, expSig);
    nbE = (nb == 0) ? 1 : nb;
    ncE = (nc == 0) ? 1 : nc;
    nrE = (nr == 0) ? 1 : nr;
    for (int r = 0; r < nrE; r++)
      for (int c = 0; c < ncE; c++)
        for (int k = 0; k < nbE; k++) begin
          burstItem_t it;
          it.col = c; it.row = r;
          if (r == 0 && c == 0 && k == 0) it.gap = 2*SL;
          else if (c == 0 && k == 0) it.gap = 3*SL;
          else it.gap = SL;
          expQ.push_back(it);
        end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && ioDisable, "R2", "busy/ioDisable after start", {busy, ioDisable}, 2'b11);
    repeat (10) @(negedge clk);
    start = 1'b1;                       // R10: request while running
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk(expQ.size() == 0, "R6", "bursts left unissued", expQ.size(), 0);
    repeat (5) @(negedge clk);
    chk(busy && ioDisable && !fastClkEn, "R2", "I/O held disabled until readout",
        {busy, ioDisable, fastClkEn}, 3'b110);
    sigOut = signature;
    start = 1'b1;                       // R10: request during hold
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(busy && done, "R10", "start ignored during hold", {busy, done}, 2'b11);
    sigAck = 1'b1;
    @(negedge clk); sigAck = 1'b0;
    chk(!ioDisable && !busy && done, "R2", "release after sigAck",
        {ioDisable, busy, done}, 3'b001);
    chk(tilePower == {2*COLS*ROWS/2{2'b10}}, "R7", "all tiles on when idle",
        tilePower[1:0], 2'b10);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] sig1, sig2, sig3, sigTmp;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !pass && !ioDisable && !fastClkEn && !shiftEn, "R1",
        "status after reset", {busy, done, pass, ioDisable, fastClkEn, shiftEn}, 0);
    chk(tilePower == {2*COLS*ROWS/2{2'b10}}, "R1", "power map after reset",
        tilePower[1:0], 2'b10);
    rstN = 1'b1;
    @(negedge clk);

    runSession(3, 2, 2, 3, 2, 32'hACE1_0001, 32'h0, sig1);
    chk(sig1 != 0, "R8", "signature nonzero", sig1, 1);
    chk(!pass, "R9", "mismatch gives fail", pass, 0);

    runSession(3, 2, 2, 3, 2, 32'hACE1_0001, sig1, sig2);
    chk(sig2 == sig1, "R8", "repeat gives same signature", sig2, sig1);
    chk(pass, "R9", "match gives pass", pass, 1);

    runSession(3, 2, 2, 3, 2, 32'h5EED_7777, sig1, sig3);
    chk(sig3 != sig1, "R8", "new seed changes signature", sig3, ~sig1);
    chk(!pass, "R9", "changed seed fails", pass, 0);

    runSession(1, 1, 0, 8, 3, 32'h0000_0F0F, 32'h0, sigTmp);   // R5 zero count
    runSession(2, 8, 1, 2, 1, 32'h1234_5678, 32'h0, sigTmp);   // R7 full height
    runSession(4, 3, 3, 1, 0, 32'h0BAD_F00D, 32'h0, sigTmp);   // R6 zero rows

    finished = 1'b1;
    report();
  end

endmodule